// File: doc/BRIEF.md
# Shared VF BAR Aperture Decoder

This block decodes memory-request addresses against a single base address register that every virtual function of one physical function shares. One base describes a stack of equal apertures, one for each enabled virtual function. The first aperture starts at the programmed base, and each later aperture follows directly after the one before it. A request that lands inside the stack is resolved to a one-based virtual-function index and to a byte offset within that function's aperture.

The per-function aperture is a power of two. A parameter sets its minimum size. A system page code raises the size when the page is larger, so that every aperture stays page aligned. The base register has a configuration write port and a read-back path. Software can size the aperture the usual way, by writing all ones and reading back the mask.

The enable, memory-space enable, function count and page code come from a neighbouring register file. Decode results are registered and appear one clock after the request.

Top module: `vfbar_decoder`

## Requirements
- R1: After reset, bar_rd_data is 0, hit_o is 0, vf_idx_o is 0 and vf_off_o is 0.
- R2: After all ones is written to the base, bar_rd_data reads 0 in every bit below log2 of the aperture size and 1 in every bit at or above it. For any written value, the read-back equals the written value with the bits below the aperture size cleared. The stored value only changes on a write or on reset.
- R3: The aperture size per function is 2^S bytes. S is the larger of APER_LOG2 and PAGE_LOG2_MIN + page_code, capped at ADDR_W-1. page_code is an unsigned exponent: code c means a system page of 2^(12+c) bytes. The read-back mask and the decode both follow a change of page_code with no write.
- R4: The aligned base (the read-back value) is the start of function 1. A request at that address hits with vf_idx_o = 1 and vf_off_o = 0.
- R5: Function N occupies the range from aligned base + (N-1)*2^S to aligned base + N*2^S - 1. A hit there gives vf_idx_o = N and vf_off_o = address - (aligned base + (N-1)*2^S).
- R6: Addresses below the aligned base miss. Addresses at or above aligned base + num_vfs*2^S miss, with no wrap past the top of the address space. num_vfs = 0 never hits.
- R7: No request hits unless vf_enable and vf_mse are both 1. Clearing either one leaves the base read-back unchanged.
- R8: Decode outputs register the request presented at a rising edge and show it after that edge. A cycle with req_valid = 0 gives hit_o = 0.
- R9: When hit_o is 0, vf_idx_o and vf_off_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_wr_en | input | 1 | Write strobe for the shared base register |
| bar_wr_data | input | ADDR_W | Value written to the base register |
| bar_rd_data | output | ADDR_W | Base read-back with bits below the aperture size cleared |
| vf_enable | input | 1 | Virtual functions enabled |
| vf_mse | input | 1 | Memory-space enable for the shared apertures |
| num_vfs | input | VF_W | Number of enabled virtual functions |
| page_code | input | PG_W | System page exponent, page = 2^(12+code) bytes |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | ADDR_W | Request address |
| hit_o | output | 1 | Registered: request fell inside an enabled aperture |
| vf_idx_o | output | VF_W | Registered one-based function index, 0 on a miss |
| vf_off_o | output | ADDR_W | Registered offset inside the aperture, 0 on a miss |

## Verification
The hardest case to reach is the top of the stack. There the last aperture ends exactly at the top of the address space, or the programmed count would reach past it, so the decode must not wrap around. A second hard case is a base written unaligned whose alignment then shifts because the page code grows without any new write. The bench builds the design with a 20-bit address so that a base close to 0xFFFFF can be programmed. It sweeps every page code, several function counts and aligned, unaligned and near-top bases. For each combination it probes the first byte, a middle byte and the last byte of every aperture, plus the bytes just outside the stack.

// File: rtl/vfbar_pkg.sv
package vfbar_pkg;

    // Smallest system page exponent (code 0 means 4 KiB)
    localparam int unsigned PAGE_LOG2_MIN = 12;

    // Effective aperture exponent: larger of the fixed size and the page, capped
    function automatic int unsigned eff_shift(input int unsigned aper_log2,
                                              input int unsigned page_log2,
                                              input int unsigned cap);
        int unsigned s;
        s = (page_log2 > aper_log2) ? page_log2 : aper_log2;
        if (s > cap) s = cap;
        return s;
    endfunction

endpackage

// File: rtl/vfbar_size_calc.sv
module vfbar_size_calc #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PG_W      = 4,
    parameter int unsigned APER_LOG2 = 12,
    localparam int unsigned SH_W     = $clog2(ADDR_W)
) (
    input  logic [PG_W-1:0]   page_code,
    output logic [SH_W-1:0]   shift,
    output logic [ADDR_W-1:0] low_mask
);
    import vfbar_pkg::*;

    always_comb begin
        int unsigned s;
        s        = eff_shift(APER_LOG2, PAGE_LOG2_MIN + 32'(page_code), ADDR_W - 1);
        shift    = SH_W'(s);
        low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
    end

endmodule

// File: rtl/vfbar_match.sv
module vfbar_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned VF_W   = 16,
    localparam int unsigned SH_W  = $clog2(ADDR_W)
) (
    input  logic              qualify,
    input  logic [ADDR_W-1:0] base_al,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SH_W-1:0]   shift,
    input  logic [ADDR_W-1:0] low_mask,
    input  logic [VF_W-1:0]   num_vfs,
    output logic              hit,
    output logic [VF_W-1:0]   idx,
    output logic [ADDR_W-1:0] off
);
    logic              above;
    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] quot;
    logic              in_stack;

    always_comb begin
        above    = (addr >= base_al);
        diff     = addr - base_al;
        quot     = diff >> shift;
        in_stack = (quot < ADDR_W'(num_vfs));
        hit      = qualify & above & in_stack;
        idx      = VF_W'(quot) + VF_W'(1);
        off      = diff & low_mask;
    end

endmodule

// File: rtl/vfbar_decoder.sv
module vfbar_decoder #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned VF_W      = 16,
    parameter int unsigned PG_W      = 4,
    parameter int unsigned APER_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bar_wr_en,
    input  logic [ADDR_W-1:0] bar_wr_data,
    output logic [ADDR_W-1:0] bar_rd_data,
    input  logic              vf_enable,
    input  logic              vf_mse,
    input  logic [VF_W-1:0]   num_vfs,
    input  logic [PG_W-1:0]   page_code,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit_o,
    output logic [VF_W-1:0]   vf_idx_o,
    output logic [ADDR_W-1:0] vf_off_o
);
    localparam int unsigned SH_W = $clog2(ADDR_W);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              hit;
        logic [VF_W-1:0]   idx;
        logic [ADDR_W-1:0] off;
    } state_t;

    state_t st_d, st_q;

    logic [SH_W-1:0]   ap_shift;
    logic [ADDR_W-1:0] ap_mask;
    logic [ADDR_W-1:0] base_al;
    logic              m_hit;
    logic [VF_W-1:0]   m_idx;
    logic [ADDR_W-1:0] m_off;

    vfbar_size_calc #(
        .ADDR_W(ADDR_W), .PG_W(PG_W), .APER_LOG2(APER_LOG2)
    ) u_size (
        .page_code(page_code),
        .shift    (ap_shift),
        .low_mask (ap_mask)
    );

    assign base_al     = st_q.base & ~ap_mask;
    assign bar_rd_data = base_al;

    vfbar_match #(
        .ADDR_W(ADDR_W), .VF_W(VF_W)
    ) u_match (
        .qualify (req_valid & vf_enable & vf_mse),
        .base_al (base_al),
        .addr    (req_addr),
        .shift   (ap_shift),
        .low_mask(ap_mask),
        .num_vfs (num_vfs),
        .hit     (m_hit),
        .idx     (m_idx),
        .off     (m_off)
    );

    always_comb begin
        st_d = st_q;
        if (bar_wr_en) begin
            st_d.base = bar_wr_data;
        end
        st_d.hit = m_hit;
        st_d.idx = m_hit ? m_idx : '0;
        st_d.off = m_hit ? m_off : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o    = st_q.hit;
    assign vf_idx_o = st_q.idx;
    assign vf_off_o = st_q.off;

endmodule

// File: rtl/vfbar_decoder_chk.sv
module vfbar_decoder_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned VF_W      = 16,
    parameter int unsigned PG_W      = 4,
    parameter int unsigned APER_LOG2 = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bar_wr_en,
    input logic [ADDR_W-1:0] bar_rd_data,
    input logic              vf_enable,
    input logic              vf_mse,
    input logic [VF_W-1:0]   num_vfs,
    input logic [PG_W-1:0]   page_code,
    input logic              req_valid,
    input logic              hit_o,
    input logic [VF_W-1:0]   vf_idx_o,
    input logic [ADDR_W-1:0] vf_off_o
);
    import vfbar_pkg::*;

    logic [31:0] chk_shift;
    always_comb chk_shift = eff_shift(APER_LOG2, PAGE_LOG2_MIN + 32'(page_code), ADDR_W - 1);

    assert_hit_needs_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(vf_enable) && $past(vf_mse)));

    assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !hit_o);

    assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (vf_idx_o != '0) && (vf_idx_o <= $past(num_vfs)));

    assert_off_in_aperture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((vf_off_o >> $past(chk_shift)) == '0));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (vf_idx_o == '0) && (vf_off_o == '0));

    assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bar_wr_en) && $stable(page_code)) |-> $stable(bar_rd_data));

endmodule

bind vfbar_decoder vfbar_decoder_chk #(
    .ADDR_W(ADDR_W), .VF_W(VF_W), .PG_W(PG_W), .APER_LOG2(APER_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bar_wr_en  (bar_wr_en),
    .bar_rd_data(bar_rd_data),
    .vf_enable  (vf_enable),
    .vf_mse     (vf_mse),
    .num_vfs    (num_vfs),
    .page_code  (page_code),
    .req_valid  (req_valid),
    .hit_o      (hit_o),
    .vf_idx_o   (vf_idx_o),
    .vf_off_o   (vf_off_o)
);

// File: tb/vfbar_decoder_bench.sv
module vfbar_decoder_bench;
    localparam int AW = 20;
    localparam int VW = 4;
    localparam int PW = 2;
    localparam int AL = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bar_wr_en = 1'b0;
    logic [AW-1:0] bar_wr_data = '0;
    logic [AW-1:0] bar_rd_data;
    logic          vf_enable = 1'b0;
    logic          vf_mse = 1'b0;
    logic [VW-1:0] num_vfs = '0;
    logic [PW-1:0] page_code = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          hit_o;
    logic [VW-1:0] vf_idx_o;
    logic [AW-1:0] vf_off_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [AW-1:0] base_wr = '0;

    always #2 clk = ~clk;

    vfbar_decoder #(.ADDR_W(AW), .VF_W(VW), .PG_W(PW), .APER_LOG2(AL)) u_vfbar_decoder (
        .clk(clk), .rst_n(rst_n), .bar_wr_en(bar_wr_en), .bar_wr_data(bar_wr_data),
        .bar_rd_data(bar_rd_data), .vf_enable(vf_enable), .vf_mse(vf_mse),
        .num_vfs(num_vfs), .page_code(page_code), .req_valid(req_valid),
        .req_addr(req_addr), .hit_o(hit_o), .vf_idx_o(vf_idx_o), .vf_off_o(vf_off_o)
    );

    function automatic int ap_shift(input int pc);
        int s;
        s = 12 + pc;
        if (s < AL) s = AL;
        return s;
    endfunction

    function automatic logic [AW-1:0] aligned(input logic [AW-1:0] b, input int pc);
        return b & ~((AW'(1) << ap_shift(pc)) - AW'(1));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_base(input logic [AW-1:0] v);
        @(negedge clk);
        bar_wr_en = 1'b1;
        bar_wr_data = v;
        base_wr = v;
        @(negedge clk);
        bar_wr_en = 1'b0;
    endtask

    // Drive one request, then compare registered outputs with the arithmetic model
    task automatic probe(input logic v, input logic [AW-1:0] a);
        int sh;
        logic [AW-1:0] bm;
        logic [AW:0] q;
        logic eh;
        logic [VW-1:0] ei;
        logic [AW-1:0] eo;
        string tag;
        sh = ap_shift(int'(page_code));
        bm = aligned(base_wr, int'(page_code));
        eh = 1'b0; ei = '0; eo = '0;
        if (v && vf_enable && vf_mse && a >= bm) begin
            q = ({1'b0, a} - {1'b0, bm}) >> sh;
            if (q < (AW+1)'(num_vfs)) begin
                eh = 1'b1;
                ei = VW'(q + 1);
                eo = (a - bm) & ((AW'(1) << sh) - AW'(1));
            end
        end
        @(negedge clk);
        req_valid = v;
        req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!(vf_enable && vf_mse)) tag = "R7";
        else if (!v) tag = "R8";
        else if (eh && ei == 1) tag = "R4";
        else if (eh) tag = "R5";
        else tag = "R6";
        check({tag, " hit"}, 32'(hit_o), 32'(eh));
        check({tag, eh ? " idx" : " idx R9"}, 32'(vf_idx_o), 32'(ei));
        check({tag, eh ? " off" : " off R9"}, 32'(vf_off_o), 32'(eo));
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd", 32'(bar_rd_data), 0);
        check("R1 hit", 32'(hit_o), 0);
        check("R1 idx", 32'(vf_idx_o), 0);
        check("R1 off", 32'(vf_off_o), 0);

        // R2/R3 size probe per page code
        write_base('1);
        for (int pc = 0; pc < 4; pc++) begin
            page_code = PW'(pc);
            @(negedge clk);
            check("R2 probe", 32'(bar_rd_data), 32'(aligned('1, pc)));
        end

        // R3 page code change re-aligns a stored unaligned base without a write
        page_code = 0;
        write_base(20'h3F123);
        check("R2 mask", 32'(bar_rd_data), 32'h3E000);
        page_code = 2;
        @(negedge clk);
        check("R3 page", 32'(bar_rd_data), 32'h3C000);

        // R7 enables
        page_code = 0;
        num_vfs = 3;
        write_base(20'h0A000);
        for (int e = 0; e < 3; e++) begin
            vf_enable = (e != 0);
            vf_mse = (e != 1);
            probe(1'b1, 20'h0A000);
            probe(1'b1, 20'h0C004);
            check("R7 rd", 32'(bar_rd_data), 32'h0A000);
        end
        vf_enable = 1'b1;
        vf_mse = 1'b1;
        probe(1'b0, 20'h0A000);  // R8 idle request

        // Main sweep
        for (int pc = 0; pc < 4; pc++) begin
            for (int bi = 0; bi < 3; bi++) begin
                for (int ni = 0; ni < 4; ni++) begin
                    int sz;
                    int nv;
                    logic [AW-1:0] bb;
                    logic [AW-1:0] bm;
                    page_code = PW'(pc);
                    nv = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 3 : 15;
                    num_vfs = VW'(nv);
                    bb = (bi == 0) ? 20'h0A000 : (bi == 1) ? 20'h3F123 : 20'hF8000;
                    write_base(bb);
                    sz = 1 << ap_shift(pc);
                    bm = aligned(bb, pc);
                    check("R2 rd", 32'(bar_rd_data), 32'(bm));
                    if (bm != 0) probe(1'b1, bm - 1);
                    for (int k = 0; k <= nv + 1; k++) begin
                        for (int j = 0; j < 3; j++) begin
                            int a;
                            a = int'(bm) + k * sz + ((j == 0) ? 0 : (j == 1) ? (sz / 2 + 3) : (sz - 1));
                            if (a < (1 << AW)) probe(1'b1, AW'(a));
                        end
                    end
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule